// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block is a synthesizable behavioural model of the command front end of a 16-bit asynchronous NOR flash. It watches the chip-enable, write-enable and output-enable strobes. From the write cycles it picks out the multi-cycle unlock sequences that guard every operation, and it starts word programming, three sizes of erase, an identification mode and a parameter-query mode. A stray write cancels a half-entered sequence.

A down-counter stands in for the internal program or erase time, which is scaled to a number of clock cycles. While that counter runs, reads return live status bits in place of array contents. The array is a small register memory that comes out of reset fully erased. All strobes are sampled on the system clock. A strobe change is therefore seen at the next rising clock edge.

Top module: `nor_cmd_engine`

## Requirements
- R1: After reset every array word reads FFFFh, the block is idle and the decoder is in read-array mode.
- R2: `dq_oe` is 1 exactly when `ce_n` and `oe_n` are both low. At all other times it is 0, and the data bus counts as floating.
- R3: A program has four writes. Low byte AAh goes to address 5555h, 55h to 2AAAh, A0h to 5555h, and a fourth write carries the target address and the 16-bit word. That word is stored once the busy time ends.
- R4: Programming can only clear bits. The stored word becomes the old word ANDed with the new word.
- R5: A sector erase has six writes: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address. It sets to FFFFh every word whose array address matches the given address above bit SECT_AW-1. Here SECT_AW is 5, so the region is 32 words. Other words are unchanged.
- R6: A block erase is the same sequence with 50h in the sixth write. It clears the region selected by the address bits above BLK_AW-1. Here BLK_AW is 7, so the region is 128 words.
- R7: A chip erase is the same sequence with 10h written to 5555h in the sixth write. It sets every word to FFFFh.
- R8: While busy, a read returns a status word with bits 15..8 and 5..0 at zero. Bit 7 is the complement of bit 7 of the word being programmed, or 0 during an erase. Bit 6 is cleared when the operation starts and inverts on each read, so the first read shows 1.
- R9: Writes that arrive while busy are ignored. They start nothing and they do not advance the decoder.
- R10: A write that breaks the expected address and data pattern returns the decoder to read-array mode, including from identification or query mode, and leaves the array unchanged.
- R11: AAh@5555h, 55h@2AAAh, 90h@5555h enters identification mode. Reads with address bit 0 at 0 return MFG_CODE (default 00A7h), and reads with bit 0 at 1 return DEV_CODE (default 27B3h). AAh@5555h, 55h@2AAAh, F0h@5555h returns to read-array mode.
- R12: AAh@5555h, 55h@2AAAh, 98h@5555h enters query mode. Addresses 10h, 11h and 12h read 0051h, 0052h and 0059h, and other addresses read 0000h.
- R13: A write's address is taken when the write becomes active, that is when the later of `ce_n` and `we_n` falls. Its data is taken when the write ends, that is when the earlier of the two rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 15 | Word address |
| dq_in | input | 16 | Data written by the host |
| dq_out | output | 16 | Read data: array word, ID code, query word or status |
| dq_oe | output | 1 | Output drive enable for the data bus |

## Verification
The hardest state to reach from the ports is the middle of a busy period. Several things are only visible there: the status toggle, the inverted bit 7, and the dropping of a complete command sequence sent while busy. The stimulus starts a program or an erase and then issues back-to-back reads at once, plus a full second program sequence, all well inside the known busy window. It then waits past the window and reads back both target addresses. The address and data latch points are checked with one write whose address and data both change partway through the strobe.

// File: rtl/nce_pkg.sv
package nce_pkg;

    localparam int BUS_AW = 15;
    localparam int DQ_W   = 16;

    localparam logic [BUS_AW-1:0] UNLOCK_A = 15'h5555;
    localparam logic [BUS_AW-1:0] UNLOCK_B = 15'h2AAA;

    localparam logic [7:0] KEY_A     = 8'hAA;
    localparam logic [7:0] KEY_B     = 8'h55;
    localparam logic [7:0] CMD_PROG  = 8'hA0;
    localparam logic [7:0] CMD_ERASE = 8'h80;
    localparam logic [7:0] CMD_ID    = 8'h90;
    localparam logic [7:0] CMD_QUERY = 8'h98;
    localparam logic [7:0] CMD_EXIT  = 8'hF0;
    localparam logic [7:0] ER_CHIP   = 8'h10;
    localparam logic [7:0] ER_SECT   = 8'h30;
    localparam logic [7:0] ER_BLK    = 8'h50;

    typedef enum logic [1:0] {
        MODE_ARRAY,
        MODE_ID,
        MODE_QUERY
    } mode_e;

    typedef enum logic [1:0] {
        OP_PROG,
        OP_SECT,
        OP_BLK,
        OP_CHIP
    } op_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_U1,
        ST_U2,
        ST_PRG,
        ST_E3,
        ST_E4,
        ST_E5
    } seq_e;

    typedef struct packed {
        op_kind_e          kind;
        logic [BUS_AW-1:0] addr;
        logic [DQ_W-1:0]   data;
    } op_t;

    // Parameter-query table: a short signature, everything else zero
    function automatic logic [DQ_W-1:0] query_word(input logic [7:0] off);
        case (off)
            8'h10:   return 16'h0051;
            8'h11:   return 16'h0052;
            8'h12:   return 16'h0059;
            default: return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/nce_bus_sampler.sv
module nce_bus_sampler
    import nce_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [BUS_AW-1:0] addr,
    input  logic [DQ_W-1:0]   dq_in,
    output logic              wr_pulse,
    output logic [BUS_AW-1:0] wr_addr,
    output logic [DQ_W-1:0]   wr_data,
    output logic              rd_start
);

    logic wr_act, wr_act_q;
    logic rd_act, rd_act_q;

    assign wr_act   = !ce_n && !we_n;
    assign rd_act   = !ce_n && !oe_n && we_n;
    assign rd_start = rd_act && !rd_act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_act_q <= 1'b0;
            rd_act_q <= 1'b0;
            wr_pulse <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_act_q <= wr_act;
            rd_act_q <= rd_act;
            wr_pulse <= !wr_act && wr_act_q;
            if (wr_act && !wr_act_q)
                wr_addr <= addr;          // later falling strobe opens the write
            if (!wr_act && wr_act_q)
                wr_data <= dq_in;         // first rising strobe closes it
        end
    end

    // R13
    wr_end_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> $past(!ce_n && !we_n, 2));

endmodule

// File: rtl/nce_decoder.sv
module nce_decoder
    import nce_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_pulse,
    input  logic [BUS_AW-1:0] wr_addr,
    input  logic [DQ_W-1:0]   wr_data,
    input  logic              busy,
    output mode_e             mode,
    output logic              op_go,
    output op_t               op
);

    seq_e  st, st_nx;
    mode_e mode_nx;
    logic  at_a, at_b;
    logic [7:0] cmd;
    logic  take;

    assign at_a = (wr_addr == UNLOCK_A);
    assign at_b = (wr_addr == UNLOCK_B);
    assign cmd  = wr_data[7:0];
    assign take = wr_pulse && !busy;

    always_comb begin
        st_nx   = st;
        mode_nx = mode;
        op_go   = 1'b0;
        op.kind = OP_PROG;
        op.addr = wr_addr;
        op.data = wr_data;
        if (take) begin
            // any write that does not fit the pattern falls back to read-array
            st_nx   = ST_IDLE;
            mode_nx = MODE_ARRAY;
            case (st)
                ST_IDLE: if (at_a && cmd == KEY_A) begin
                    st_nx = ST_U1; mode_nx = mode;
                end
                ST_U1: if (at_b && cmd == KEY_B) begin
                    st_nx = ST_U2; mode_nx = mode;
                end
                ST_U2: if (at_a) begin
                    case (cmd)
                        CMD_PROG:  st_nx   = ST_PRG;
                        CMD_ERASE: st_nx   = ST_E3;
                        CMD_ID:    mode_nx = MODE_ID;
                        CMD_QUERY: mode_nx = MODE_QUERY;
                        default:   mode_nx = MODE_ARRAY;
                    endcase
                end
                ST_PRG: begin
                    op_go   = 1'b1;
                    op.kind = OP_PROG;
                end
                ST_E3: if (at_a && cmd == KEY_A) st_nx = ST_E4;
                ST_E4: if (at_b && cmd == KEY_B) st_nx = ST_E5;
                ST_E5: begin
                    if (at_a && cmd == ER_CHIP) begin
                        op_go = 1'b1; op.kind = OP_CHIP;
                    end else if (cmd == ER_SECT) begin
                        op_go = 1'b1; op.kind = OP_SECT;
                    end else if (cmd == ER_BLK) begin
                        op_go = 1'b1; op.kind = OP_BLK;
                    end
                end
                default: st_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            mode <= MODE_ARRAY;
        end else begin
            st   <= st_nx;
            mode <= mode_nx;
        end
    end

    // R11
    busy_in_array_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> mode == MODE_ARRAY);

    // R9
    ignore_busy_write_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_pulse) |=> st == $past(st));

endmodule

// File: rtl/nce_busy_timer.sv
module nce_busy_timer
    import nce_pkg::*;
#(
    parameter int PROG_CYC  = 40,
    parameter int ERASE_CYC = 120
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     op_go,
    input  op_kind_e kind,
    output logic     busy,
    output logic     done
);

    localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt;

    assign busy = (cnt != '0);
    assign done = (cnt == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (op_go)
            cnt <= (kind == OP_PROG) ? CNT_W'(PROG_CYC) : CNT_W'(ERASE_CYC);
        else if (busy)
            cnt <= cnt - CNT_W'(1);
    end

endmodule

// File: rtl/nce_store.sv
module nce_store
    import nce_pkg::*;
#(
    parameter int              ARRAY_AW = 9,
    parameter int              SECT_AW  = 5,
    parameter int              BLK_AW   = 7,
    parameter logic [DQ_W-1:0] MFG_CODE = 16'h00A7,
    parameter logic [DQ_W-1:0] DEV_CODE = 16'h27B3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_go,
    input  op_t               op,
    input  logic              done,
    input  logic              busy,
    input  logic              rd_start,
    input  mode_e             mode,
    input  logic [BUS_AW-1:0] addr,
    output logic [DQ_W-1:0]   dq_out
);

    localparam int DEPTH = 1 << ARRAY_AW;

    logic [DQ_W-1:0]     mem [DEPTH];
    op_t                 op_q;
    logic                tgl;
    logic [ARRAY_AW-1:0] op_a;
    logic [ARRAY_AW-1:0] rd_a;
    int                  er_shift;
    logic [DQ_W-1:0]     status;

    assign op_a = op_q.addr[ARRAY_AW-1:0];
    assign rd_a = addr[ARRAY_AW-1:0];

    always_comb begin
        case (op_q.kind)
            OP_SECT: er_shift = SECT_AW;
            OP_BLK:  er_shift = BLK_AW;
            default: er_shift = ARRAY_AW;
        endcase
    end

    assign status = {8'h00,
                     (op_q.kind == OP_PROG) ? ~op_q.data[7] : 1'b0,
                     tgl, 6'h00};

    always_comb begin
        if (busy)
            dq_out = status;
        else begin
            case (mode)
                MODE_ID:    dq_out = rd_a[0] ? DEV_CODE : MFG_CODE;
                MODE_QUERY: dq_out = query_word(addr[7:0]);
                default:    dq_out = mem[rd_a];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q <= '0;
            tgl  <= 1'b0;
        end else if (op_go) begin
            op_q <= op;
            tgl  <= 1'b0;
        end else if (busy && rd_start) begin
            tgl  <= ~tgl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '1;
        end else if (done) begin
            if (op_q.kind == OP_PROG)
                mem[op_a] <= mem[op_a] & op_q.data;
            else begin
                for (int i = 0; i < DEPTH; i++) begin
                    if ((ARRAY_AW'(i) >> er_shift) == (op_a >> er_shift))
                        mem[i] <= '1;
                end
            end
        end
    end

endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
    import nce_pkg::*;
#(
    parameter int              ARRAY_AW  = 9,
    parameter int              SECT_AW   = 5,
    parameter int              BLK_AW    = 7,
    parameter int              PROG_CYC  = 40,
    parameter int              ERASE_CYC = 120,
    parameter logic [15:0]     MFG_CODE  = 16'h00A7,
    parameter logic [15:0]     DEV_CODE  = 16'h27B3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ce_n,
    input  logic        we_n,
    input  logic        oe_n,
    input  logic [14:0] addr,
    input  logic [15:0] dq_in,
    output logic [15:0] dq_out,
    output logic        dq_oe
);

    logic              wr_pulse;
    logic [BUS_AW-1:0] wr_addr;
    logic [DQ_W-1:0]   wr_data;
    logic              rd_start;
    mode_e             mode;
    logic              op_go;
    op_t               op;
    logic              busy;
    logic              done;

    assign dq_oe = !ce_n && !oe_n;

    nce_bus_sampler u_smp (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_in(dq_in), .wr_pulse(wr_pulse),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_start(rd_start)
    );

    nce_decoder u_dec (
        .clk(clk), .rst(rst), .wr_pulse(wr_pulse), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .mode(mode), .op_go(op_go), .op(op)
    );

    nce_busy_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_tmr (
        .clk(clk), .rst(rst), .op_go(op_go), .kind(op.kind),
        .busy(busy), .done(done)
    );

    nce_store #(
        .ARRAY_AW(ARRAY_AW), .SECT_AW(SECT_AW), .BLK_AW(BLK_AW),
        .MFG_CODE(MFG_CODE), .DEV_CODE(DEV_CODE)
    ) u_mem (
        .clk(clk), .rst(rst), .op_go(op_go), .op(op), .done(done),
        .busy(busy), .rd_start(rd_start), .mode(mode), .addr(addr),
        .dq_out(dq_out)
    );

    // R3
    launch_busy_chk: assert property (@(posedge clk) disable iff (rst)
        op_go |=> busy);

    // R8
    status_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && dq_oe) |-> dq_out[15:8] == 8'h00);

endmodule

// File: tb/nor_cmd_engine_tb.sv
`timescale 1ns/1ps
module nor_cmd_engine_tb;

    localparam int PROG_CYC  = 40;
    localparam int ERASE_CYC = 120;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [14:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic        dq_oe;

    always #2 clk = ~clk;

    nor_cmd_engine #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [15:0] act_q[$];
    int          checks = 0;
    int          fails  = 0;
    bit          finished = 1'b0;

    // monitor: pairs each observed value with the expectation queued first
    initial begin
        forever begin
            wait (act_q.size() > 0);
            begin
                exp_t        e;
                logic [15:0] a;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                checks++;
                if (a !== e.exp) begin
                    fails++;
                    $display("FAIL %s: actual %04h expected %04h", e.tag, a, e.exp);
                end
            end
        end
    end

    task automatic expect_val(input logic [15:0] e, input string tag);
        exp_t it;
        it.exp = e;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic wr(input logic [14:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; dq_in = d; ce_n = 0; we_n = 0; oe_n = 1;
        repeat (2) @(negedge clk);
        we_n = 1; ce_n = 1;
        repeat (2) @(negedge clk);
    endtask

    task automatic rd(input logic [14:0] a, input logic [15:0] e, input string tag);
        expect_val(e, tag);
        @(negedge clk);
        addr = a; ce_n = 0; oe_n = 0; we_n = 1;
        repeat (2) @(negedge clk);
        act_q.push_back(dq_out);
        ce_n = 1; oe_n = 1;
        @(negedge clk);
    endtask

    task automatic unlock();
        wr(15'h5555, 16'h00AA);
        wr(15'h2AAA, 16'h0055);
    endtask

    task automatic send_prog(input logic [14:0] a, input logic [15:0] d);
        unlock();
        wr(15'h5555, 16'h00A0);
        wr(a, d);
    endtask

    task automatic prog(input logic [14:0] a, input logic [15:0] d);
        send_prog(a, d);
        repeat (PROG_CYC + 20) @(negedge clk);
    endtask

    task automatic send_erase(input logic [14:0] a, input logic [7:0] code);
        unlock();
        wr(15'h5555, 16'h0080);
        unlock();
        wr(a, {8'h00, code});
    endtask

    task automatic oe_probe(input logic c, input logic o, input logic e, input string tag);
        expect_val({15'h0, e}, tag);
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = 1;
        @(negedge clk);
        act_q.push_back({15'h0, dq_oe});
        ce_n = 1; oe_n = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        repeat (2) @(negedge clk);

        // R1: erased after reset
        rd(15'h0000, 16'hFFFF, "R1 word 0 after reset");
        rd(15'h01FF, 16'hFFFF, "R1 last word after reset");

        // R2: output enable
        oe_probe(0, 1, 0, "R2 ce low oe high");
        oe_probe(1, 0, 0, "R2 ce high oe low");
        oe_probe(0, 0, 1, "R2 ce and oe low");

        // R3 / R8 / R9: program with status reads and an ignored sequence
        send_prog(15'h0010, 16'h1234);
        rd(15'h0010, 16'h00C0, "R8 program status first read");
        rd(15'h0010, 16'h0080, "R8 program status second read");
        send_prog(15'h0020, 16'h0000);        // R9: sent while busy
        repeat (PROG_CYC + 20) @(negedge clk);
        rd(15'h0010, 16'h1234, "R3 programmed word");
        rd(15'h0020, 16'hFFFF, "R9 write while busy ignored");

        // R4: AND with previous contents
        prog(15'h0010, 16'hFF0F);
        rd(15'h0010, 16'h1204, "R4 program only clears bits");

        // R13: address from write start, data from write end
        unlock();
        wr(15'h5555, 16'h00A0);
        @(negedge clk);
        addr = 15'h0030; dq_in = 16'hAAAA; ce_n = 0; we_n = 0; oe_n = 1;
        @(negedge clk);
        addr = 15'h0031; dq_in = 16'h0F0F;
        @(negedge clk);
        we_n = 1; ce_n = 1;
        repeat (PROG_CYC + 20) @(negedge clk);
        rd(15'h0030, 16'h0F0F, "R13 data from end, address from start");
        rd(15'h0031, 16'hFFFF, "R13 late address not used");

        // R10: broken sequence then recovery
        unlock();
        wr(15'h1234, 16'h00A0);
        wr(15'h0005, 16'h0000);
        repeat (PROG_CYC + 20) @(negedge clk);
        rd(15'h0005, 16'hFFFF, "R10 broken sequence leaves array");
        prog(15'h0005, 16'h5555);
        rd(15'h0005, 16'h5555, "R10 decoder recovers after break");

        // R11: identification mode and exit
        unlock();
        wr(15'h5555, 16'h0090);
        rd(15'h0000, 16'h00A7, "R11 manufacturer code");
        rd(15'h0001, 16'h27B3, "R11 device code");
        unlock();
        wr(15'h5555, 16'h00F0);
        rd(15'h0010, 16'h1204, "R11 exit back to array");

        // R12: query mode, left through a stray write (R10)
        unlock();
        wr(15'h5555, 16'h0098);
        rd(15'h0010, 16'h0051, "R12 query word 10h");
        rd(15'h0011, 16'h0052, "R12 query word 11h");
        rd(15'h0012, 16'h0059, "R12 query word 12h");
        rd(15'h0020, 16'h0000, "R12 query other word");
        wr(15'h0100, 16'h0000);
        rd(15'h0010, 16'h1204, "R10 stray write leaves query mode");

        // R5: sector erase of sector 0 with status reads (R8)
        prog(15'h0025, 16'h00F0);
        send_erase(15'h0012, 8'h30);
        rd(15'h0012, 16'h0040, "R8 erase status first read");
        rd(15'h0012, 16'h0000, "R8 erase status second read");
        repeat (ERASE_CYC + 20) @(negedge clk);
        rd(15'h0010, 16'hFFFF, "R5 sector word erased");
        rd(15'h0005, 16'hFFFF, "R5 sector word erased low");
        rd(15'h0030, 16'h0F0F, "R5 neighbour sector kept");
        rd(15'h0025, 16'h00F0, "R5 neighbour sector kept low");

        // R6: block erase of block 1
        prog(15'h0090, 16'h1111);
        prog(15'h0100, 16'h2222);
        send_erase(15'h0085, 8'h50);
        repeat (ERASE_CYC + 20) @(negedge clk);
        rd(15'h0090, 16'hFFFF, "R6 block word erased");
        rd(15'h0030, 16'h0F0F, "R6 lower block kept");
        rd(15'h0100, 16'h2222, "R6 upper block kept");

        // R7: chip erase
        send_erase(15'h5555, 8'h10);
        repeat (ERASE_CYC + 20) @(negedge clk);
        rd(15'h0030, 16'hFFFF, "R7 chip erase low word");
        rd(15'h0100, 16'hFFFF, "R7 chip erase high word");

        wait (act_q.size() == 0);
        @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule